// File: doc/BRIEF.md
# Splittable Word-Serial Barrett Modular Multiplier

This block computes a modular product A·B mod N using Barrett reduction on a word-serial datapath. Each clock cycle it takes one 16-bit word of a scanned operand, most significant word first, multiplies it against the whole of a wide operand, and folds the result into a shifted accumulator. One product is built this way, then two Barrett estimates: the estimated quotient times the reciprocal constant, and the corrected quotient times the modulus. The result is the remainder. At most two conditional subtractions of N then bring it below N. The block does no trial division.

The datapath is built from two lanes. Each lane is half the modulus width plus a guard word. The `split_mode` input is sampled when an operation starts. With it low, the two lanes act as one full-width multiplier for a modulus of K = 2·HALF_W bits. With it high, they become two independent multipliers for HALF_W-bit moduli. Each has its own operands, modulus and constant, and no carry or borrow passes between the lanes.

All data ports are lane-packed, DATA_W = 2·(HALF_W+GUARD_W) bits wide. In full mode a value sits at bit 0 of the port. In split mode lane 0 uses bits [LANE_W-1:0] and lane 1 uses bits [DATA_W-1:LANE_W], where LANE_W = HALF_W+GUARD_W. The caller supplies the reciprocal constant floor(2^(2k)/N), with k the modulus width of the mode. Computing that constant is the caller's job, as are exponent sequencing and recombination.

Top module: `bmm_splittable_barrett`

## Requirements
- R1: With `split_mode` low at start, N of exactly K bits (bit K-1 set), A and B below N and `recip` = floor(2^(2K)/N), `result` equals A·B mod N at bit 0, with all higher bits zero.
- R2: With `split_mode` high at start, each lane (lane 0 at bits [LANE_W-1:0], lane 1 at bits [DATA_W-1:LANE_W]) returns its own A·B mod N for a HALF_W-bit modulus with its top bit set, given its own constant floor(2^(2·HALF_W)/N).
- R3: In split mode, the lane 0 result depends only on the lane 0 inputs; changing any lane 1 input leaves it unchanged.
- R4: Every result is reduced: each returned value is strictly below its modulus, including the corner cases A=B=N-1 with the smallest and the largest modulus of the width.
- R5: A full-mode operation raises `done` exactly 3·(DATA_W/16)+2 cycles after the clock edge that accepts `start` (20 cycles at the default sizes).
- R6: A split-mode operation raises `done` exactly 3·(LANE_W/16)+2 cycles after acceptance (11 at the default sizes), never later than full mode.
- R7: Latency depends only on the mode, not on operand values; an operand of zero gives result zero in the same number of cycles.
- R8: `done` is high for one cycle at a time, and `result` holds the answer during that cycle.
- R9: `start` is accepted only while the block is idle; a `start` pulse during an operation creates no extra `done` and does not disturb the running result.
- R10: `split_mode` is captured at acceptance; changing it during an operation changes neither the result nor the latency.
- R11: After reset, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| split_mode | input | 1 | 0: one full-width product, 1: two half-width products |
| op_a | input | DATA_W | Multiplicand (wide operand), lane-packed |
| op_b | input | DATA_W | Multiplier (scanned operand), lane-packed |
| modulus | input | DATA_W | Modulus N, lane-packed |
| recip | input | DATA_W | Barrett constant floor(2^(2k)/N), lane-packed |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | A·B mod N, lane-packed |

## Verification
On every cycle the assertions check four things: each `done` is a single-cycle pulse, it belongs to an accepted start, it arrives after exactly the latency of the mode captured at that start, and the value it returns lies below the modulus of each active lane. Reduction below N is necessary but not sufficient. Only the bench's scenarios can show that the remainder is the right one. Those scenarios compare full and split results against products computed independently. They show lane isolation by altering only lane 1, and that start pulses and mode changes in mid-operation are ignored.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

   // Width of one scanned operand slice.
   localparam int unsigned WORD_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_FOLD
   } bmm_state_e;

   // Three word-serial passes, in order.
   typedef enum logic [1:0] {
      PH_PROD,   // A * B
      PH_QEST,   // (P >> (k-1)) * mu
      PH_QN      // (q2 >> (k+1)) * N
   } bmm_phase_e;

endpackage

// File: rtl/bmm_word_mac.sv
// One word-serial step: acc << WORD_W plus wide * word, either as one
// full-width sum or as two isolated half-accumulators.
module bmm_word_mac #(
   parameter int unsigned LANE_W = 48,
   parameter int unsigned WORD_W = 16
) (
   input  logic                  split_i,
   input  logic [2*LANE_W-1:0]   wide_i,
   input  logic [WORD_W-1:0]     word_lo_i,
   input  logic [WORD_W-1:0]     word_hi_i,
   input  logic [4*LANE_W-1:0]   acc_i,
   output logic [4*LANE_W-1:0]   acc_o
);
   localparam int unsigned ACC_W  = 4*LANE_W;
   localparam int unsigned HACC_W = 2*LANE_W;
   localparam int unsigned PP_W   = LANE_W + WORD_W;

   logic [WORD_W-1:0] word [2];
   logic [PP_W-1:0]   pp   [2];
   logic [ACC_W-1:0]  full_sum;
   logic [HACC_W-1:0] part_lo;
   logic [HACC_W-1:0] part_hi;

   assign word[0] = word_lo_i;
   assign word[1] = word_hi_i;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign pp[g] = PP_W'(wide_i[g*LANE_W +: LANE_W]) * PP_W'(word[g]);
   end

   assign full_sum = (acc_i << WORD_W) + (ACC_W'(pp[1]) << LANE_W) + ACC_W'(pp[0]);
   assign part_lo  = (acc_i[HACC_W-1:0] << WORD_W) + HACC_W'(pp[0]);
   assign part_hi  = (acc_i[ACC_W-1:HACC_W] << WORD_W) + HACC_W'(pp[1]);
   assign acc_o    = split_i ? {part_hi, part_lo} : full_sum;

endmodule

// File: rtl/bmm_qslice.sv
// Quotient slice: accumulator >> (k + OFFSET), k taken from the mode.
module bmm_qslice #(
   parameter int unsigned LANE_W = 48,
   parameter int unsigned HALF_W = 32,
   parameter int          OFFSET = -1
) (
   input  logic                split_i,
   input  logic [4*LANE_W-1:0] acc_i,
   output logic [2*LANE_W-1:0] q_o
);
   localparam int unsigned DATA_W   = 2*LANE_W;
   localparam int unsigned SH_FULL  = 2*HALF_W + OFFSET;
   localparam int unsigned SH_SPLIT = HALF_W + OFFSET;

   logic [LANE_W-1:0] q_lo;
   logic [LANE_W-1:0] q_hi;

   assign q_lo = LANE_W'(acc_i[DATA_W-1:0] >> SH_SPLIT);
   assign q_hi = LANE_W'(acc_i[2*DATA_W-1:DATA_W] >> SH_SPLIT);
   assign q_o  = split_i ? {q_hi, q_lo} : DATA_W'(acc_i >> SH_FULL);

endmodule

// File: rtl/bmm_fold.sv
// One conditional subtraction of the modulus, full width or per lane.
module bmm_fold #(
   parameter int unsigned LANE_W = 48
) (
   input  logic                split_i,
   input  logic [2*LANE_W-1:0] rem_i,
   input  logic [2*LANE_W-1:0] mod_i,
   output logic [2*LANE_W-1:0] rem_o
);
   logic [2*LANE_W-1:0] full_v;
   logic [LANE_W-1:0]   lane_v [2];

   assign full_v = (rem_i >= mod_i) ? rem_i - mod_i : rem_i;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LANE_W-1:0] r_l;
      logic [LANE_W-1:0] n_l;
      assign r_l       = rem_i[g*LANE_W +: LANE_W];
      assign n_l       = mod_i[g*LANE_W +: LANE_W];
      assign lane_v[g] = (r_l >= n_l) ? r_l - n_l : r_l;
   end

   assign rem_o = split_i ? {lane_v[1], lane_v[0]} : full_v;

endmodule

// File: rtl/bmm_splittable_barrett.sv
module bmm_splittable_barrett import bmm_pkg::*; #(
   parameter  int unsigned HALF_W  = 32,
   parameter  int unsigned GUARD_W = 16,
   localparam int unsigned LANE_W  = HALF_W + GUARD_W,
   localparam int unsigned DATA_W  = 2*LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              split_mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] modulus,
   input  logic [DATA_W-1:0] recip,
   output logic              done,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned ACC_W       = 4*LANE_W;
   localparam int unsigned WORDS_FULL  = DATA_W / WORD_W;
   localparam int unsigned WORDS_SPLIT = LANE_W / WORD_W;
   localparam int unsigned CNT_W       = $clog2(WORDS_FULL);

   if (HALF_W % WORD_W != 0) begin : g_bad_half
      $error("HALF_W must be a whole number of scan words");
   end
   if (GUARD_W < WORD_W || GUARD_W % WORD_W != 0) begin : g_bad_guard
      $error("GUARD_W must be at least one scan word and word aligned");
   end

   bmm_state_e        state_q;
   bmm_phase_e        phase_q;
   logic              mode_q;
   logic              fold_q;
   logic              done_q;
   logic              idle;
   logic              last_word;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] scan_q, scan_nx;
   logic [DATA_W-1:0] wide_q, mod_q, mu_q;
   logic [DATA_W-1:0] prod_q, rem_q;
   logic [DATA_W-1:0] q1, q3, t_pk, rem_nx, fold_out;
   logic [ACC_W-1:0]  acc_q, acc_nx;
   logic [WORD_W-1:0] word_hi, word_lo;
   logic [LANE_W-1:0] diff_lo, diff_hi;

   // Low product bits kept for the remainder: one field per active lane.
   function automatic logic [DATA_W-1:0] pack_low(input logic split,
                                                  input logic [ACC_W-1:0] v);
      return split ? {v[DATA_W +: LANE_W], v[LANE_W-1:0]} : v[DATA_W-1:0];
   endfunction

   assign idle      = (state_q == ST_IDLE);
   assign word_hi   = scan_q[DATA_W-1 -: WORD_W];
   assign word_lo   = mode_q ? scan_q[LANE_W-1 -: WORD_W] : word_hi;
   assign scan_nx   = mode_q ? {scan_q[DATA_W-1:LANE_W] << WORD_W, scan_q[LANE_W-1:0] << WORD_W}
                             : scan_q << WORD_W;
   assign last_word = (cnt_q == CNT_W'(mode_q ? WORDS_SPLIT-1 : WORDS_FULL-1));

   bmm_word_mac #(.LANE_W(LANE_W), .WORD_W(WORD_W)) u_mac (
      .split_i   (mode_q),
      .wide_i    (wide_q),
      .word_lo_i (word_lo),
      .word_hi_i (word_hi),
      .acc_i     (acc_q),
      .acc_o     (acc_nx)
   );

   bmm_qslice #(.LANE_W(LANE_W), .HALF_W(HALF_W), .OFFSET(-1)) u_q1 (
      .split_i (mode_q), .acc_i (acc_nx), .q_o (q1)
   );

   bmm_qslice #(.LANE_W(LANE_W), .HALF_W(HALF_W), .OFFSET(1)) u_q3 (
      .split_i (mode_q), .acc_i (acc_nx), .q_o (q3)
   );

   // Remainder estimate P - q3*N: exact and below 3N, so the low bits suffice.
   assign t_pk    = pack_low(mode_q, acc_nx);
   assign diff_lo = prod_q[LANE_W-1:0] - t_pk[LANE_W-1:0];
   assign diff_hi = prod_q[LANE_W +: LANE_W] - t_pk[LANE_W +: LANE_W];
   assign rem_nx  = mode_q ? {diff_hi, diff_lo} : prod_q - t_pk;

   bmm_fold #(.LANE_W(LANE_W)) u_fold (
      .split_i (mode_q), .rem_i (rem_q), .mod_i (mod_q), .rem_o (fold_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_PROD;
         mode_q  <= 1'b0;
         fold_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         scan_q  <= '0;
         wide_q  <= '0;
         mod_q   <= '0;
         mu_q    <= '0;
         prod_q  <= '0;
         rem_q   <= '0;
         acc_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mode_q  <= split_mode;
                  wide_q  <= op_a;
                  scan_q  <= op_b;
                  mod_q   <= modulus;
                  mu_q    <= recip;
                  acc_q   <= '0;
                  cnt_q   <= '0;
                  phase_q <= PH_PROD;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (!last_word) begin
                  acc_q  <= acc_nx;
                  scan_q <= scan_nx;
                  cnt_q  <= cnt_q + 1'b1;
               end else begin
                  acc_q <= '0;
                  cnt_q <= '0;
                  case (phase_q)
                     PH_PROD: begin
                        prod_q  <= pack_low(mode_q, acc_nx);
                        scan_q  <= q1;
                        wide_q  <= mu_q;
                        phase_q <= PH_QEST;
                     end
                     PH_QEST: begin
                        scan_q  <= q3;
                        wide_q  <= mod_q;
                        phase_q <= PH_QN;
                     end
                     default: begin
                        rem_q   <= rem_nx;
                        fold_q  <= 1'b0;
                        state_q <= ST_FOLD;
                     end
                  endcase
               end
            end
            ST_FOLD: begin
               rem_q  <= fold_out;
               fold_q <= 1'b1;
               if (fold_q) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done   = done_q;
   assign result = rem_q;

endmodule

// File: rtl/bmm_checks.sv
module bmm_checks #(
   parameter int unsigned HALF_W  = 32,
   parameter int unsigned GUARD_W = 16
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              start,
   input logic                              split_mode,
   input logic                              idle,
   input logic                              mode_q,
   input logic                              done,
   input logic [2*(HALF_W+GUARD_W)-1:0]     result,
   input logic [2*(HALF_W+GUARD_W)-1:0]     mod_q
);
   localparam int unsigned LANE_W    = HALF_W + GUARD_W;
   localparam int unsigned DATA_W    = 2*LANE_W;
   localparam int unsigned LAT_FULL  = 3*(DATA_W/16) + 2;
   localparam int unsigned LAT_SPLIT = 3*(LANE_W/16) + 2;
   localparam int unsigned LAT_W     = $clog2(LAT_FULL + 2);

   logic             pend_q;
   logic             pend_split_q;
   logic [LAT_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q       <= 1'b0;
         pend_split_q <= 1'b0;
         age_q        <= '0;
      end else if (start && idle) begin
         pend_q       <= 1'b1;
         pend_split_q <= split_mode;
         age_q        <= '0;
      end else if (pend_q) begin
         age_q <= age_q + 1'b1;
         if (done) pend_q <= 1'b0;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R8
   AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend_q);                                                    // R9
   AST_LAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pend_split_q) |-> (age_q == LAT_W'(LAT_FULL)));            // R5
   AST_LAT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pend_split_q) |-> (age_q == LAT_W'(LAT_SPLIT)));            // R6
   AST_FULL_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_q) |-> (result < mod_q));                             // R4
   AST_SPLIT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> ((result[LANE_W-1:0] < mod_q[LANE_W-1:0]) &&
                            (result[DATA_W-1:LANE_W] < mod_q[DATA_W-1:LANE_W]))); // R4

endmodule

bind bmm_splittable_barrett bmm_checks #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .split_mode (split_mode),
   .idle       (idle),
   .mode_q     (mode_q),
   .done       (done),
   .result     (result),
   .mod_q      (mod_q)
);

// File: tb/sim_bmm_splittable_barrett.sv
module sim_bmm_splittable_barrett;
   localparam int unsigned HALF_W    = 32;
   localparam int unsigned GUARD_W   = 16;
   localparam int unsigned LANE_W    = HALF_W + GUARD_W;
   localparam int unsigned DW        = 2*LANE_W;
   localparam int unsigned K         = 2*HALF_W;
   localparam int          CLK_PERIOD = 10;
   localparam int          LAT_FULL  = 3*(DW/16) + 2;
   localparam int          LAT_SPLIT = 3*(LANE_W/16) + 2;

   typedef logic [2*DW-1:0] wide_t;
   typedef logic [DW-1:0]   data_t;
   typedef struct {
      data_t val;
      int    t0;
      int    lat;
      string tag;
   } exp_t;

   logic  clk = 1'b0;
   logic  rst_n = 1'b0;
   logic  start = 1'b0;
   logic  split_mode = 1'b0;
   data_t op_a = '0, op_b = '0, modulus = '0, recip = '0;
   logic  done;
   data_t result;

   exp_t  sbq[$];
   int    n_cmp = 0, n_bad = 0, cyc = 0, done_seen = 0;
   bit    finished = 1'b0;

   bmm_splittable_barrett #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u0 (
      .clk, .rst_n, .start, .split_mode, .op_a, .op_b, .modulus, .recip, .done, .result
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, data_t act, data_t exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_int(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic data_t ref_mod(data_t a, data_t b, data_t n);
      wide_t p = wide_t'(a) * wide_t'(b);
      return data_t'(p % wide_t'(n));
   endfunction

   function automatic data_t mu_of(int unsigned k, data_t n);
      wide_t one = 1;
      return data_t'((one << (2*k)) / wide_t'(n));
   endfunction

   function automatic data_t pack2(data_t hi, data_t lo);
      return (hi << LANE_W) | lo;
   endfunction

   function automatic data_t rnd_full_mod();
      return data_t'({1'b1, $urandom(), 31'($urandom())});
   endfunction

   function automatic data_t rnd_lane_mod();
      return data_t'({1'b1, 31'($urandom())});
   endfunction

   function automatic data_t rnd_below(data_t n);
      return data_t'({$urandom(), $urandom(), $urandom()}) % n;
   endfunction

   // Monitor: pops the scoreboard on each done.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            exp_t e;
            done_seen++;
            if (sbq.size() == 0) begin
               n_cmp++;
               n_bad++;
               $display("FAIL R9 unexpected done: actual result %h expected no done", result);
            end else begin
               e = sbq.pop_front();
               check(e.tag, result, e.val);
               check_int({e.tag, " latency"}, cyc - e.t0, e.lat);
            end
         end
      end
   end

   // Driver: queue the expectation, then pulse start for one cycle.
   task automatic launch(bit split, data_t a, data_t b, data_t n, data_t mu,
                         data_t exp, string tag);
      exp_t e;
      @(negedge clk);
      e.val = exp;
      e.t0  = cyc + 1;
      e.lat = split ? LAT_SPLIT : LAT_FULL;
      e.tag = tag;
      sbq.push_back(e);
      split_mode = split;
      op_a = a; op_b = b; modulus = n; recip = mu;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   task automatic full_op(data_t a, data_t b, data_t n, string tag);
      launch(1'b0, a, b, n, mu_of(K, n), ref_mod(a, b, n), tag);
      drain();
   endtask

   task automatic split_op(data_t a1, data_t b1, data_t n1,
                           data_t a0, data_t b0, data_t n0, string tag);
      launch(1'b1, pack2(a1, a0), pack2(b1, b0), pack2(n1, n0),
             pack2(mu_of(HALF_W, n1), mu_of(HALF_W, n0)),
             pack2(ref_mod(a1, b1, n1), ref_mod(a0, b0, n0)), tag);
      drain();
   endtask

   initial begin
      repeat (LAT_FULL * 2000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      data_t n, n1, n0, a0, b0, base;
      int    seen0;
      repeat (3) @(negedge clk);
      check("R11 done after reset", data_t'(done), '0);
      check("R11 result after reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 result idle", result, '0);

      // Full-width products
      for (int i = 0; i < 5; i++) begin
         n = rnd_full_mod();
         full_op(rnd_below(n), rnd_below(n), n, "R1 full random");
      end
      n = {DW{1'b0}} | {K{1'b1}};
      full_op(n - 1, n - 1, n, "R4 full largest modulus");
      n = data_t'(1) << (K - 1);
      full_op(n - 1, n - 1, n, "R4 full smallest modulus");
      n = rnd_full_mod();
      full_op('0, rnd_below(n), n, "R7 full zero operand");
      full_op(data_t'(1), n - 1, n, "R1 full unit operand");

      // Split products
      for (int i = 0; i < 5; i++) begin
         n1 = rnd_lane_mod();
         n0 = rnd_lane_mod();
         split_op(rnd_below(n1), rnd_below(n1), n1, rnd_below(n0), rnd_below(n0), n0,
                  "R2 split random");
      end
      n1 = data_t'(32'hFFFF_FFFF);
      n0 = data_t'(1) << (HALF_W - 1);
      split_op(n1 - 1, n1 - 1, n1, n0 - 1, n0 - 1, n0, "R4 split extreme moduli");
      split_op('0, '0, rnd_lane_mod(), '0, data_t'(5), rnd_lane_mod(), "R7 split zero operands");

      // Lane isolation: same lane 0, two different lane 1 inputs
      n0 = rnd_lane_mod();
      a0 = rnd_below(n0);
      b0 = rnd_below(n0);
      n1 = rnd_lane_mod();
      split_op(rnd_below(n1), rnd_below(n1), n1, a0, b0, n0, "R3 lane0 with lane1 set A");
      n1 = data_t'(32'hFFFF_FFFF);
      split_op(n1 - 1, n1 - 2, n1, a0, b0, n0, "R3 lane0 with lane1 set B");

      // Start during an operation is ignored
      seen0 = done_seen;
      n = rnd_full_mod();
      base = rnd_below(n);
      launch(1'b0, base, n - 1, n, mu_of(K, n), ref_mod(base, n - 1, n), "R9 running op");
      repeat (3) @(negedge clk);
      op_a = n - 1; op_b = n - 2; split_mode = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      split_mode = 1'b0;
      drain();
      repeat (LAT_FULL + 5) @(negedge clk);
      check_int("R9 done count", done_seen - seen0, 1);

      // Mode change during an operation is ignored
      n = rnd_full_mod();
      base = rnd_below(n);
      launch(1'b0, base, base, n, mu_of(K, n), ref_mod(base, base, n), "R10 mode flip");
      split_mode = 1'b1;
      drain();
      split_mode = 1'b0;

      repeat (3) @(negedge clk);
      check("R8 done low after pulse", data_t'(done), '0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule